// File: doc/BRIEF.md
# Miss Wait Register Allocator

When a cache lookup misses, the missing request has to be parked while memory fetches the line. This block holds those parked requests. Each pipeline owns a small set of wait registers. A miss arriving on a pipeline takes the lowest-numbered free register of that pipeline. When all of them are busy, it spills into one of two registers that every pipeline shares. When even those are full, the block tells the pipeline to put the request back in its queue.

Each captured entry keeps the following:
- the originating pipe;
- the request number and address;
- a priority one step more urgent than the request's own;
- a preload flag and a lock flag, derived from the request kind;
- a latency counter, loaded from the current memory latency plus one.

Once the counter has run down to zero, the entry raises a fill request toward the memory side. The entry is freed on the clock edge at which that fill is accepted. The memory data path and the tag update are handled elsewhere.

Top module: `miss_wait_alloc`

## Requirements
- R1: A miss on pipe p is captured in the lowest-indexed free wait register that belongs to pipe p. An entry is not free in the cycle in which it is being released; it can be allocated from the next cycle on.
- R2: The stored priority equals the request priority minus one, modulo 2^PRIO_W, so a priority of 0 is stored as all ones.
- R3: A captured entry loads its counter with mem_latency_i + 1 and counts down once per cycle. It requests a fill from the cycle after the counter reaches zero, so fill_valid_o for that entry first appears mem_latency_i + 1 cycles after the capture edge.
- R4: The kind code selects the stored flags:
  - 0 (load) gives preload=0, lock=0;
  - 1 (store) gives preload=1, lock=0;
  - 2 (preload) gives preload=1, with lock taken from miss_lock_i;
  - 3 is treated as a load.
- R5: If every register of pipe p is busy, the miss goes to shared register A if it is free, else to shared register B. The entry records pipe p, and that value is reported on fill_pipe_o.
- R6: If the pipe's registers and both shared registers are all busy, requeue_o is high in that same cycle and nothing is captured. requeue_o is low whenever miss_valid_i is low.
- R7: The fill outputs carry the selected entry's pipe, request number, address, stored priority and flags. Among entries whose count has expired, the lowest flat index wins, in this order:
  1. the registers of pipe 0 in index order;
  2. the registers of pipe 1, and so on for further pipes;
  3. shared register A;
  4. shared register B.
- R8: An expired entry keeps fill_valid_o asserted until fill_ready_i is high. Its valid bit clears on the edge at which the fill is accepted.
- R9: After reset no entry is valid, fill_valid_o is low, and requeue_o is low.
- R10: While miss_valid_i is low, no entry is captured, whatever the other miss inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | A missing request is presented this cycle |
| miss_pipe_i | input | PIPE_W | Pipe the miss comes from |
| miss_kind_i | input | 2 | Request kind: 0 load, 1 store, 2 preload, 3 treated as load |
| miss_reqno_i | input | REQNO_W | Request number |
| miss_addr_i | input | ADDR_W | Request address |
| miss_prio_i | input | PRIO_W | Request priority, 0 most urgent |
| miss_lock_i | input | 1 | Lock request carried by a preload |
| mem_latency_i | input | LAT_W | Memory latency in cycles |
| requeue_o | output | 1 | No register was free; the request must return to its queue |
| fill_valid_o | output | 1 | An expired entry requests a fill |
| fill_ready_i | input | 1 | Fill request accepted this cycle |
| fill_pipe_o | output | PIPE_W | Pipe of the filling entry |
| fill_reqno_o | output | REQNO_W | Request number of the filling entry |
| fill_addr_o | output | ADDR_W | Address of the filling entry |
| fill_prio_o | output | PRIO_W | Stored priority of the filling entry |
| fill_preload_o | output | 1 | Stored preload flag |
| fill_lock_o | output | 1 | Stored lock flag |

## Verification
The assertions check the following on every cycle:
- at most one register is written per miss, and only a free one;
- the stored priority is decremented on capture, and the flag encoding follows the kind code;
- the counter is loaded and then steps down by one;
- a requeue leaves the set of valid entries without additions;
- a pending fill is held until it is accepted;
- a grant goes only to an expired entry.

The scenarios are needed to show the rest: the lowest-index choice within a pipe, the spill order into the two shared registers, the fill ordering across entries that expire together, and the exact cycle at which each fill appears.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD    = 2'd0,
    KIND_STORE   = 2'd1,
    KIND_PRELOAD = 2'd2,
    KIND_RSVD    = 2'd3
  } miss_kind_e;

  typedef struct packed {
    logic preload;
    logic lock;
  } wait_flags_t;

  function automatic wait_flags_t encode_flags(input logic [1:0] kind, input logic lock_in);
    wait_flags_t f;
    unique case (miss_kind_e'(kind))
      KIND_STORE:   f = '{preload: 1'b1, lock: 1'b0};
      KIND_PRELOAD: f = '{preload: 1'b1, lock: lock_in};
      default:      f = '{preload: 1'b0, lock: 1'b0};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/mwr_entry.sv
module mwr_entry
  import mwr_pkg::*;
#(
  parameter int PIPE_W  = 1,
  parameter int REQNO_W = 8,
  parameter int ADDR_W  = 32,
  parameter int PRIO_W  = 8,
  parameter int LAT_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               release_i,
  input  logic [PIPE_W-1:0]  pipe_i,
  input  logic [REQNO_W-1:0] reqno_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [PRIO_W-1:0]  prio_i,
  input  logic [1:0]         kind_i,
  input  logic               lock_i,
  input  logic [LAT_W-1:0]   latency_i,
  output logic               valid_o,
  output logic               ready_o,
  output logic [PIPE_W-1:0]  pipe_o,
  output logic [REQNO_W-1:0] reqno_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [PRIO_W-1:0]  prio_o,
  output logic               preload_o,
  output logic               lock_o
);

  localparam int CNT_W = LAT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  wait_flags_t      flags_d;

  assign flags_d = encode_flags(kind_i, lock_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      cnt_q     <= '0;
      pipe_o    <= '0;
      reqno_o   <= '0;
      addr_o    <= '0;
      prio_o    <= '0;
      preload_o <= 1'b0;
      lock_o    <= 1'b0;
    end else if (load_i) begin
      valid_o   <= 1'b1;
      cnt_q     <= CNT_W'(latency_i) + CNT_W'(1);
      pipe_o    <= pipe_i;
      reqno_o   <= reqno_i;
      addr_o    <= addr_i;
      prio_o    <= prio_i - PRIO_W'(1);
      preload_o <= flags_d.preload;
      lock_o    <= flags_d.lock;
    end else if (release_i) begin
      valid_o <= 1'b0;
    end else if (valid_o && cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign ready_o = valid_o && (cnt_q == '0);

  AST_LOAD_INTO_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o); // R1
  AST_PRIO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> prio_o == $past(prio_i) - PRIO_W'(1)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == CNT_W'($past(latency_i)) + CNT_W'(1)); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cnt_q != '0 && !load_i) |=> (valid_o && cnt_q == $past(cnt_q) - CNT_W'(1))); // R3
  AST_FLAGS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (kind_i == KIND_LOAD || kind_i == KIND_RSVD)) |=> (!preload_o && !lock_o)); // R4
  AST_FLAGS_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && kind_i == KIND_STORE) |=> (preload_o && !lock_o)); // R4
  AST_FLAGS_PRELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && kind_i == KIND_PRELOAD) |=> (preload_o && lock_o == $past(lock_i))); // R4
  AST_RELEASE_EXPIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> ready_o); // R8

endmodule

// File: rtl/mwr_alloc.sv
module mwr_alloc #(
  parameter int NUM_PIPES = 2,
  parameter int WAITS     = 2,
  parameter int PIPE_W    = 1,
  localparam int NUM_ENT  = NUM_PIPES * WAITS + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               miss_valid_i,
  input  logic [PIPE_W-1:0]  miss_pipe_i,
  input  logic [NUM_ENT-1:0] valid_i,
  output logic [NUM_ENT-1:0] load_o,
  output logic               requeue_o
);

  localparam int SH_A = NUM_PIPES * WAITS;
  localparam int SH_B = SH_A + 1;

  logic own_found;

  always_comb begin
    load_o    = '0;
    requeue_o = 1'b0;
    own_found = 1'b0;
    if (miss_valid_i) begin
      for (int p = 0; p < NUM_PIPES; p++) begin
        for (int i = 0; i < WAITS; i++) begin
          if (PIPE_W'(p) == miss_pipe_i && !own_found && !valid_i[p*WAITS+i]) begin
            load_o[p*WAITS+i] = 1'b1;
            own_found         = 1'b1;
          end
        end
      end
      if (!own_found) begin
        if (!valid_i[SH_A])      load_o[SH_A] = 1'b1;
        else if (!valid_i[SH_B]) load_o[SH_B] = 1'b1;
        else                     requeue_o    = 1'b1;
      end
    end
  end

  AST_ALLOC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o)); // R1
  AST_ALLOC_XOR_REQUEUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i |-> ($countones(load_o) + 32'(requeue_o)) == 1); // R6

endmodule

// File: rtl/mwr_fill_arb.sv
module mwr_fill_arb #(
  parameter int NUM_ENT = 6,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ENT-1:0] ready_i,
  input  logic               fill_ready_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   sel_o,
  output logic [NUM_ENT-1:0] grant_o
);

  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    for (int e = NUM_ENT - 1; e >= 0; e--) begin
      if (ready_i[e]) begin
        any_o = 1'b1;
        sel_o = IDX_W'(e);
      end
    end
  end

  assign grant_o = (any_o && fill_ready_i) ? (NUM_ENT'(1) << sel_o) : '0;

  AST_GRANT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R7
  AST_GRANT_EXPIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~ready_i) == '0); // R7

endmodule

// File: rtl/miss_wait_alloc.sv
module miss_wait_alloc #(
  parameter int NUM_PIPES = 2,
  parameter int WAITS     = 2,
  parameter int REQNO_W   = 8,
  parameter int ADDR_W    = 32,
  parameter int PRIO_W    = 8,
  parameter int LAT_W     = 8,
  localparam int PIPE_W   = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               miss_valid_i,
  input  logic [PIPE_W-1:0]  miss_pipe_i,
  input  logic [1:0]         miss_kind_i,
  input  logic [REQNO_W-1:0] miss_reqno_i,
  input  logic [ADDR_W-1:0]  miss_addr_i,
  input  logic [PRIO_W-1:0]  miss_prio_i,
  input  logic               miss_lock_i,
  input  logic [LAT_W-1:0]   mem_latency_i,
  output logic               requeue_o,
  output logic               fill_valid_o,
  input  logic               fill_ready_i,
  output logic [PIPE_W-1:0]  fill_pipe_o,
  output logic [REQNO_W-1:0] fill_reqno_o,
  output logic [ADDR_W-1:0]  fill_addr_o,
  output logic [PRIO_W-1:0]  fill_prio_o,
  output logic               fill_preload_o,
  output logic               fill_lock_o
);

  localparam int NUM_ENT = NUM_PIPES * WAITS + 2;
  localparam int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  logic [NUM_ENT-1:0] ent_valid, ent_ready, ent_load, ent_grant;
  logic [NUM_ENT-1:0][PIPE_W-1:0]  ent_pipe;
  logic [NUM_ENT-1:0][REQNO_W-1:0] ent_reqno;
  logic [NUM_ENT-1:0][ADDR_W-1:0]  ent_addr;
  logic [NUM_ENT-1:0][PRIO_W-1:0]  ent_prio;
  logic [NUM_ENT-1:0] ent_preload, ent_lock;
  logic [IDX_W-1:0]   fill_sel;

  mwr_alloc #(
    .NUM_PIPES(NUM_PIPES),
    .WAITS    (WAITS),
    .PIPE_W   (PIPE_W)
  ) u_alloc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .miss_valid_i(miss_valid_i),
    .miss_pipe_i (miss_pipe_i),
    .valid_i     (ent_valid),
    .load_o      (ent_load),
    .requeue_o   (requeue_o)
  );

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    mwr_entry #(
      .PIPE_W (PIPE_W),
      .REQNO_W(REQNO_W),
      .ADDR_W (ADDR_W),
      .PRIO_W (PRIO_W),
      .LAT_W  (LAT_W)
    ) u_entry (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (ent_load[e]),
      .release_i(ent_grant[e]),
      .pipe_i   (miss_pipe_i),
      .reqno_i  (miss_reqno_i),
      .addr_i   (miss_addr_i),
      .prio_i   (miss_prio_i),
      .kind_i   (miss_kind_i),
      .lock_i   (miss_lock_i),
      .latency_i(mem_latency_i),
      .valid_o  (ent_valid[e]),
      .ready_o  (ent_ready[e]),
      .pipe_o   (ent_pipe[e]),
      .reqno_o  (ent_reqno[e]),
      .addr_o   (ent_addr[e]),
      .prio_o   (ent_prio[e]),
      .preload_o(ent_preload[e]),
      .lock_o   (ent_lock[e])
    );
  end

  mwr_fill_arb #(
    .NUM_ENT(NUM_ENT)
  ) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ready_i     (ent_ready),
    .fill_ready_i(fill_ready_i),
    .any_o       (fill_valid_o),
    .sel_o       (fill_sel),
    .grant_o     (ent_grant)
  );

  always_comb begin
    fill_pipe_o    = '0;
    fill_reqno_o   = '0;
    fill_addr_o    = '0;
    fill_prio_o    = '0;
    fill_preload_o = 1'b0;
    fill_lock_o    = 1'b0;
    for (int e = 0; e < NUM_ENT; e++) begin
      if (fill_sel == IDX_W'(e)) begin
        fill_pipe_o    = ent_pipe[e];
        fill_reqno_o   = ent_reqno[e];
        fill_addr_o    = ent_addr[e];
        fill_prio_o    = ent_prio[e];
        fill_preload_o = ent_preload[e];
        fill_lock_o    = ent_lock[e];
      end
    end
  end

  AST_REQUEUE_NO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    requeue_o |=> (ent_valid & ~$past(ent_valid)) == '0); // R6
  AST_REQUEUE_NEEDS_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_valid_i |-> !requeue_o); // R6
  AST_IDLE_NO_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_valid_i |=> (ent_valid & ~$past(ent_valid)) == '0); // R10
  AST_FILL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o && !fill_ready_i) |=> fill_valid_o); // R8

endmodule

// File: tb/miss_wait_alloc_test.sv
`timescale 1ns/1ps
module miss_wait_alloc_test;

  localparam int P = 2;
  localparam int N = 2;
  localparam int E = P * N + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [0:0]  miss_pipe = '0;
  logic [1:0]  miss_kind = '0;
  logic [7:0]  miss_reqno = '0;
  logic [31:0] miss_addr = '0;
  logic [7:0]  miss_prio = '0;
  logic        miss_lock = 1'b0;
  logic [7:0]  mem_lat = '0;
  logic        fill_ready = 1'b0;
  logic        requeue, fill_valid, fill_pre, fill_lock;
  logic [0:0]  fill_pipe;
  logic [7:0]  fill_reqno, fill_prio;
  logic [31:0] fill_addr;

  always #2 clk = ~clk;

  miss_wait_alloc uut (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(miss_valid), .miss_pipe_i(miss_pipe), .miss_kind_i(miss_kind),
    .miss_reqno_i(miss_reqno), .miss_addr_i(miss_addr), .miss_prio_i(miss_prio),
    .miss_lock_i(miss_lock), .mem_latency_i(mem_lat),
    .requeue_o(requeue), .fill_valid_o(fill_valid), .fill_ready_i(fill_ready),
    .fill_pipe_o(fill_pipe), .fill_reqno_o(fill_reqno), .fill_addr_o(fill_addr),
    .fill_prio_o(fill_prio), .fill_preload_o(fill_pre), .fill_lock_o(fill_lock)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string scen = "R9";

  bit        m_valid [E];
  int        m_cnt   [E];
  int        m_pipe  [E];
  int        m_reqno [E];
  int        m_addr  [E];
  int        m_prio  [E];
  bit        m_pre   [E];
  bit        m_lock  [E];

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", scen, req, act, exp);
    end
  endtask

  function automatic int find_alloc(int pipe);
    for (int i = 0; i < N; i++) if (!m_valid[pipe*N+i]) return pipe*N + i;
    if (!m_valid[P*N]) return P*N;
    if (!m_valid[P*N+1]) return P*N + 1;
    return -1;
  endfunction

  function automatic int find_fill();
    for (int e = 0; e < E; e++) if (m_valid[e] && m_cnt[e] == 0) return e;
    return -1;
  endfunction

  task automatic step(bit mv, int pipe, int kind, int reqno, int addr, int prio, bit lock, int lat, bit rdy);
    int a, f;
    @(negedge clk);
    miss_valid = mv; miss_pipe = pipe[0:0]; miss_kind = kind[1:0];
    miss_reqno = reqno[7:0]; miss_addr = addr; miss_prio = prio[7:0];
    miss_lock = lock; mem_lat = lat[7:0]; fill_ready = rdy;
    #1;
    a = mv ? find_alloc(pipe) : -1;
    f = find_fill();
    chk("R6 requeue", requeue, (mv && a < 0) ? 1 : 0);
    chk("R3 fill_valid", fill_valid, (f >= 0) ? 1 : 0);
    if (f >= 0) begin
      chk("R7 reqno", fill_reqno, m_reqno[f]);
      chk("R7 addr", fill_addr, m_addr[f] & 32'hffff_ffff);
      chk("R2 prio", fill_prio, m_prio[f]);
      chk("R4 preload", fill_pre, m_pre[f]);
      chk("R4 lock", fill_lock, m_lock[f]);
      chk("R5 pipe", fill_pipe, m_pipe[f]);
    end
    for (int e = 0; e < E; e++) begin
      if (e == a) begin
        m_valid[e] = 1'b1; m_cnt[e] = lat + 1; m_pipe[e] = pipe; m_reqno[e] = reqno & 255;
        m_addr[e] = addr; m_prio[e] = (prio - 1) & 255;
        m_pre[e] = (kind == 1 || kind == 2);
        m_lock[e] = (kind == 2) ? lock : 1'b0;
      end else if (e == f && rdy) begin
        m_valid[e] = 1'b0;
      end else if (m_valid[e] && m_cnt[e] != 0) begin
        m_cnt[e]--;
      end
    end
    @(posedge clk);
  endtask

  task automatic idle(int n, bit rdy);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, rdy);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #400000;
    failures++;
    checks++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int e = 0; e < E; e++) begin
      m_valid[e] = 0; m_cnt[e] = 0; m_pipe[e] = 0; m_reqno[e] = 0;
      m_addr[e] = 0; m_prio[e] = 0; m_pre[e] = 0; m_lock[e] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    scen = "R9";
    chk("R9 fill_valid", fill_valid, 0);
    chk("R9 requeue", requeue, 0);
    rst_n = 1'b1;
    idle(2, 1);

    scen = "R1";
    step(1, 0, 0, 8'h11, 32'h100, 5, 0, 2, 0);
    step(1, 0, 1, 8'h12, 32'h140, 6, 1, 2, 0);
    step(1, 1, 2, 8'h13, 32'h180, 7, 1, 2, 0);
    step(1, 1, 3, 8'h14, 32'h1c0, 8, 1, 2, 0);
    idle(4, 0);
    scen = "R7";
    idle(6, 1);

    scen = "R2";
    step(1, 1, 2, 8'h21, 32'h200, 0, 0, 0, 1);
    idle(3, 1);

    scen = "R5";
    step(1, 0, 0, 8'h31, 32'h300, 9, 0, 5, 0);
    step(1, 0, 1, 8'h32, 32'h304, 9, 0, 5, 0);
    step(1, 0, 2, 8'h33, 32'h308, 9, 1, 5, 0);
    step(1, 0, 0, 8'h34, 32'h30c, 9, 0, 5, 0);
    scen = "R6";
    step(1, 0, 0, 8'h35, 32'h310, 9, 0, 5, 0);
    step(1, 1, 1, 8'h36, 32'h314, 9, 0, 5, 0);
    step(1, 1, 0, 8'h37, 32'h318, 9, 0, 5, 0);
    step(1, 1, 0, 8'h38, 32'h31c, 9, 0, 5, 0);
    scen = "R8";
    idle(8, 0);
    step(1, 0, 0, 8'h39, 32'h320, 9, 0, 1, 1);
    step(1, 0, 0, 8'h3a, 32'h324, 9, 0, 1, 1);
    idle(12, 1);

    scen = "R10";
    for (int k = 0; k < 6; k++)
      step(0, $urandom_range(1), $urandom_range(3), $urandom_range(255), $urandom, $urandom_range(255), 1, 1, 0);
    idle(4, 1);

    scen = "R3 random";
    for (int k = 0; k < 4000; k++)
      step($urandom_range(99) < 50, $urandom_range(1), $urandom_range(3), $urandom_range(255),
           $urandom, $urandom_range(255), $urandom_range(1), $urandom_range(7), $urandom_range(99) < 70);
    scen = "R8 drain";
    idle(30, 1);
    finish_run();
  end

endmodule